// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Trigger Cell

This cell turns one asynchronous input line into a latched pending flag. The line first passes through a two-flop synchroniser. The synchronised level is then compared with its value one cycle earlier to find rising and falling transitions. Depending on its programmed mode, the cell sets a sticky pending bit on a rising edge, a falling edge, either edge, a high level or a low level. The synchronised level is also driven out so that a reader can observe the line's present state.

The cell is programmed by a single byte with a write strobe. Each cell carries a fixed 3-bit index. The byte takes effect only when four things are true: its write flag is set, its index field matches the cell's index, the strobe is high, and the block-match enable from the surrounding logic is high. The same byte can both change the trigger mode and clear the pending bit. A larger controller instantiates one cell per source and gathers the pending bits itself.

Top module: `irq_trig_cell`

## Requirements
- R1: After reset, pend_o is 0, both mask bits are set and level select is 0. Until a byte is accepted, no line activity sets pend_o.
- R2: A byte is accepted only when all of these hold: cfg_we_i is 1, blk_en_i is 1, bit 7 is 1, and bits 6:4 equal CELL_IDX. A byte that misses any of these leaves the mode unchanged and does not clear pend_o.
- R3: level_o equals the value line_i held two clock edges earlier (two-flop synchroniser).
- R4: Edge mode is bit 0 = 0. In edge mode with rising unmasked (bit 2 = 0), a 0-to-1 change of the synchronised line sets pend_o. The flag appears on the third clock edge after line_i changes.
- R5: In edge mode with falling unmasked (bit 1 = 0), a 1-to-0 change of the synchronised line sets pend_o, with the same latency as R4.
- R6: In edge mode with both masks clear, either transition sets pend_o.
- R7: Level mode is bit 0 = 1. In level mode with rising unmasked, pend_o is set on every edge at which the synchronised line is 1.
- R8: In level mode with falling unmasked, pend_o is set on every edge at which the synchronised line is 0.
- R9: While both mask bits (bits 1 and 2) are set, pend_o never goes from 0 to 1.
- R10: An accepted byte with bit 3 set clears pend_o on the same edge that loads the new mode bits.
- R11: When an accepted clear and a qualifying event under the mode in force fall on the same edge, the event wins and pend_o stays 1.
- R12: An accepted byte that clears pend_o and enters level mode while the line is already at the active level lets pend_o return to 1 on the next edge.
- R13: In edge mode, pend_o stays 1 after the line returns to its previous level, until an accepted clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous interrupt source line |
| cfg_byte_i | input | 8 | Configuration byte: bit 0 level select, bit 1 mask falling, bit 2 mask rising, bit 3 clear, bits 6:4 index, bit 7 write flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| blk_en_i | input | 1 | Block-match enable from the enclosing controller |
| pend_o | output | 1 | Latched pending flag |
| level_o | output | 1 | Synchronised line level |

## Verification
The bench aims a clear write at the exact edge where a rising transition is being latched. A design that let the clear win there would lose that interrupt for good. The bench also switches into level mode with a clear while the line is already active. A design that stayed low there, or that never dropped on the write, would show a one-cycle error in pend_o. Bytes that miss the index, the write flag, the strobe or the block enable are sent with unmasking contents while the line toggles, so a partial decoder shows up as a spurious pend_o. Edge latency is compared on every cycle, which catches a missing synchroniser flop or a missing history flop.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;
  localparam int CFG_W   = 8;
  localparam int B_LVL   = 0;
  localparam int B_MFE   = 1;
  localparam int B_MRE   = 2;
  localparam int B_CLR   = 3;
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = 3;
  localparam int B_WR    = 7;

  typedef struct packed {
    logic lvl_sel;
    logic mask_fe;
    logic mask_re;
  } trig_cfg_t;

  localparam trig_cfg_t CFG_RST = '{lvl_sel: 1'b0, mask_fe: 1'b1, mask_re: 1'b1};
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b0;
        else if (i == 0) ff_q[i] <= d_i;
        else ff_q[i] <= ff_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_dec.sv
module irq_cfg_dec
  import irq_cell_pkg::*;
#(
  parameter int CELL_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] byte_i,
  input  logic             we_i,
  input  logic             blk_en_i,
  output trig_cfg_t        cfg_o,
  output logic             clr_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CELL_IDX);

  logic      accept;
  trig_cfg_t cfg_q;

  assign accept = we_i && blk_en_i && byte_i[B_WR]
                  && (byte_i[IDX_LSB +: IDX_W] == MY_IDX);
  assign clr_o  = accept && byte_i[B_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else if (accept) begin
      cfg_q.lvl_sel <= byte_i[B_LVL];
      cfg_q.mask_fe <= byte_i[B_MFE];
      cfg_q.mask_re <= byte_i[B_MRE];
    end
  end

  assign cfg_o = cfg_q;

  // R2: mode holds without an accepted byte
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(cfg_q));
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_cell_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trig_cfg_t cfg_i,
  input  logic      clr_i,
  input  logic      s_i,
  output logic      pend_o
);
  logic prev_q, pend_q;
  logic rise, fall, edge_hit, lvl_hit, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;
  end

  assign rise     = s_i && !prev_q;
  assign fall     = !s_i && prev_q;
  assign edge_hit = (!cfg_i.mask_re && rise) || (!cfg_i.mask_fe && fall);
  assign lvl_hit  = (!cfg_i.mask_re && s_i) || (!cfg_i.mask_fe && !s_i);
  assign evt      = cfg_i.lvl_sel ? lvl_hit : edge_hit;

  // event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt || (pend_q && !clr_i);
  end

  assign pend_o = pend_q;

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mask_fe && cfg_i.mask_re && !pend_q) |=> !pend_q);
  assert_rise_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.lvl_sel && !cfg_i.mask_re && s_i && !prev_q) |=> pend_q);
  assert_edge_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.lvl_sel && pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_cell_pkg::*;
#(
  parameter int CELL_IDX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [CFG_W-1:0] cfg_byte_i,
  input  logic             cfg_we_i,
  input  logic             blk_en_i,
  output logic             pend_o,
  output logic             level_o
);
  logic      line_s;
  logic      clr;
  trig_cfg_t cfg;

  irq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  irq_cfg_dec #(.CELL_IDX(CELL_IDX)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (cfg_byte_i),
    .we_i    (cfg_we_i),
    .blk_en_i(blk_en_i),
    .cfg_o   (cfg),
    .clr_o   (clr)
  );

  irq_detect u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (cfg),
    .clr_i (clr),
    .s_i   (line_s),
    .pend_o(pend_o)
  );

  assign level_o = line_s;

  // R10: clear under a fully masked mode leaves nothing pending
  assert_clear_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && cfg.mask_fe && cfg.mask_re) |=> !pend_o);
endmodule

// File: tb/tb_irq_trig_cell.sv
module tb_irq_trig_cell;
  localparam int IDX = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic [7:0] cbyte = 8'h00;
  logic       we = 1'b0;
  logic       blk = 1'b0;
  logic       pend_o, level_o;

  int    n_tests = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  irq_trig_cell #(.CELL_IDX(IDX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .cfg_byte_i(cbyte),
    .cfg_we_i(we), .blk_en_i(blk), .pend_o(pend_o), .level_o(level_o)
  );

  // behavioural reference: line history, mode, pending
  bit h1, h2, h3;
  bit m_lvl, m_mfe, m_mre, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_lvl = 0; m_mfe = 1; m_mre = 1; m_pend = 0;
    end else begin
      bit s, p, ev, acc;
      s = h2; p = h3;
      if (m_lvl) ev = (!m_mre && s) || (!m_mfe && !s);
      else       ev = (!m_mre && s && !p) || (!m_mfe && !s && p);
      acc = we && blk && cbyte[7] && (int'(cbyte[6:4]) == IDX);
      m_pend = ev || (m_pend && !(acc && cbyte[3]));
      if (acc) begin m_lvl = cbyte[0]; m_mfe = cbyte[1]; m_mre = cbyte[2]; end
      h3 = h2; h2 = h1; h1 = line;
    end
  end

  task automatic chk(input string req, input bit got, input bit exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " pend"}, pend_o, m_pend);
      chk("R3 level", level_o, h2);
    end
  end

  function automatic logic [7:0] mk(bit lvl, bit mfe, bit mre, bit clr, int idx);
    return {1'b1, 3'(idx), clr, mre, mfe, lvl};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b, bit bl);
    @(negedge clk); cbyte = b; we = 1'b1; blk = bl;
    @(negedge clk); we = 1'b0; blk = 1'b0; cbyte = 8'h00;
  endtask

  task automatic toggle(int n);
    for (int i = 0; i < n; i++) begin line = ~line; step(4); end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pend", pend_o, 1'b0);
    cur_req = "R1"; toggle(4);
    cur_req = "R9"; wr(mk(1, 1, 1, 1, IDX), 1); toggle(4);
    wr(mk(0, 1, 1, 1, IDX), 1); toggle(3);

    cur_req = "R2"; line = 0; step(4);
    wr(mk(0, 0, 0, 0, 2), 1);
    wr(mk(0, 0, 0, 0, IDX) & 8'h7F, 1);
    wr(mk(0, 0, 0, 0, IDX), 0);
    @(negedge clk); cbyte = mk(0, 0, 0, 0, IDX); blk = 1; step(1);
    cbyte = 8'h00; blk = 0;
    toggle(4);
    chk("R2 ignored bytes", pend_o, 1'b0);

    cur_req = "R4"; line = 0; wr(mk(0, 1, 0, 1, IDX), 1); step(4);
    line = 1; step(2); chk("R4 latency", pend_o, 1'b0); step(1);
    chk("R4 set", pend_o, 1'b1);
    cur_req = "R13"; line = 0; step(6); chk("R13 sticky", pend_o, 1'b1);
    cur_req = "R10"; wr(mk(0, 0, 1, 1, IDX), 1); chk("R10 cleared", pend_o, 1'b0);

    cur_req = "R5"; step(3); line = 1; step(6); chk("R5 no rise", pend_o, 1'b0);
    line = 0; step(3); chk("R5 fall", pend_o, 1'b1);
    cur_req = "R6"; wr(mk(0, 0, 0, 1, IDX), 1); step(3);
    line = 1; step(4); chk("R6 rise", pend_o, 1'b1);
    wr(mk(0, 0, 0, 1, IDX), 1); step(2);
    line = 0; step(4); chk("R6 fall", pend_o, 1'b1);

    cur_req = "R11"; wr(mk(0, 1, 0, 1, IDX), 1); step(4);
    line = 1; step(1);
    @(negedge clk); cbyte = mk(0, 1, 0, 1, IDX); we = 1; blk = 1;
    @(negedge clk); we = 0; blk = 0; cbyte = 8'h00;
    chk("R11 event wins", pend_o, 1'b1);

    cur_req = "R12"; wr(mk(0, 1, 1, 1, IDX), 1); step(2);
    @(negedge clk); cbyte = mk(1, 1, 0, 1, IDX); we = 1; blk = 1;
    @(negedge clk); we = 0; blk = 0; cbyte = 8'h00;
    chk("R12 cleared by write", pend_o, 1'b0);
    @(negedge clk); chk("R12 reassert", pend_o, 1'b1);

    cur_req = "R7"; wr(mk(1, 1, 0, 1, IDX), 1); toggle(4);
    cur_req = "R8"; wr(mk(1, 0, 1, 1, IDX), 1); toggle(4);
    line = 1; step(4); wr(mk(1, 0, 1, 1, IDX), 1); step(1);
    chk("R8 high line no pend", pend_o, 1'b0);
    line = 0; step(3); chk("R8 low line", pend_o, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule